// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps the active-lane mask of one warp of a SIMD-threaded processor while the warp runs through nested if/else regions. Every lane executes every instruction, but only lanes whose bit is set in `active_mask` may commit a result. The sequencer sends one control operation per cycle: a region-entry operation that narrows the mask to the lanes whose predicate bit is set, an else-switch that moves to the lanes of the region that did not take the first path, and a reconvergence operation that brings back the mask held before the region. Both paths are run one after the other, and the mask widens again once both are done.

Each region entry saves two masks on an internal LIFO of parameterised depth. The first is the mask before entry and the second is the mask of lanes that took the first path. From these two the else-switch computes the lanes that were active but not taken. The block raises `skip_path` when the mask just produced by an entry or an else-switch has no lanes, so the sequencer can jump over that path. A push onto a full LIFO, or a pop or an else-switch on an empty one, is a fault. A fault is sticky, and until reset it freezes the block.

The control FSM has three states. `ST_CONVERGED` means the LIFO is empty and the warp is not inside any region. `ST_DIVERGED` means at least one region is open. `ST_FAULT` is the frozen error state. The transitions are:
- CONVERGED to DIVERGED on an accepted entry.
- DIVERGED to CONVERGED on an accepted reconvergence that empties the LIFO.
- CONVERGED or DIVERGED to FAULT on any illegal operation.
- FAULT holds until reset.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset `active_mask` is all ones, `skip_path` is 0 and `stack_fault` is 0.
- R2: An entry operation (`op_code` = 2'b01) sets `active_mask` to the old mask AND `lane_pred` and saves the old mask. Predicate bits of inactive lanes have no effect. The new mask appears on the cycle after the operation is sampled.
- R3: An else-switch (`op_code` = 2'b10) sets `active_mask` to the innermost saved mask AND NOT the lanes that took the first path of that region.
- R4: A reconvergence (`op_code` = 2'b11) restores the innermost saved mask and discards that entry. Nested regions unwind in last-in first-out order.
- R5: After an entry or an else-switch, `skip_path` is 1 exactly when the new mask is all zero. A reconvergence clears `skip_path`.
- R6: When `op_valid` is 0, or when `op_code` = 2'b00, the mask, `skip_path` and `stack_fault` do not change.
- R7: An entry when DEPTH regions are already open sets `stack_fault` and leaves the mask unchanged. DEPTH nested entries are accepted without a fault.
- R8: A reconvergence or an else-switch while no region is open sets `stack_fault` and leaves the mask unchanged.
- R9: Once `stack_fault` is set it stays set, and every operation is ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Control operation present this cycle |
| op_code | input | 2 | 00 none, 01 region entry, 10 else-switch, 11 reconvergence |
| lane_pred | input | LANES | Per-lane predicate bits, used by region entry |
| active_mask | output | LANES | Lanes allowed to commit results |
| skip_path | output | 1 | The path just entered has no active lanes |
| stack_fault | output | 1 | Sticky overflow or underflow error |

## Verification
The mask function is driven with several predicate shapes, and each tells a different possible error apart:
- Two-level nesting with disjoint halves shows whether the else-switch uses the saved mask rather than inverting the current mask.
- A predicate whose set bits include inactive lanes shows whether inactive lanes are masked out on entry.
- An entry whose predicate selects none of the active lanes, nested inside an outer region, checks that `skip_path` rises and that the following else-switch restores the full region.
- An all-zero predicate at top level checks the skip case at the outermost region.

Directed cases then push to exactly DEPTH and one beyond it, pop and switch on an empty LIFO, and confirm that the fault freezes the mask against later operations.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PUSH = 2'b01,
        OP_FLIP = 2'b10,
        OP_POP  = 2'b11
    } div_op_e;

    typedef enum logic [1:0] {
        ST_CONVERGED = 2'b00,
        ST_DIVERGED  = 2'b01,
        ST_FAULT     = 2'b10
    } div_state_e;

endpackage

// File: rtl/simt_mask_lifo.sv
module simt_mask_lifo #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LANES-1:0] wr_saved,
    input  logic [LANES-1:0] wr_taken,
    output logic [LANES-1:0] rd_saved,
    output logic [LANES-1:0] rd_taken,
    output logic [CW-1:0]    depth,
    output logic             empty,
    output logic             full,
    output logic             last
);

    logic [LANES-1:0] sel_saved [DEPTH];
    logic [LANES-1:0] sel_taken [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth <= '0;
        end else if (push) begin
            depth <= depth + CW'(1);
        end else if (pop) begin
            depth <= depth - CW'(1);
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            logic [LANES-1:0] saved_q;
            logic [LANES-1:0] taken_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    saved_q <= '0;
                    taken_q <= '0;
                end else if (push && (depth == CW'(g))) begin
                    saved_q <= wr_saved;
                    taken_q <= wr_taken;
                end
            end

            assign sel_saved[g] = (depth == CW'(g + 1)) ? saved_q : '0;
            assign sel_taken[g] = (depth == CW'(g + 1)) ? taken_q : '0;
        end
    endgenerate

    always_comb begin
        rd_saved = '0;
        rd_taken = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rd_saved = rd_saved | sel_saved[i];
            rd_taken = rd_taken | sel_taken[i];
        end
    end

    assign empty = (depth == '0);
    assign full  = (depth == CW'(DEPTH));
    assign last  = (depth == CW'(1));

endmodule

// File: rtl/simt_mask_calc.sv
module simt_mask_calc
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32
) (
    input  div_op_e          op,
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] pred,
    input  logic [LANES-1:0] top_saved,
    input  logic [LANES-1:0] top_taken,
    output logic [LANES-1:0] taken_mask,
    output logic [LANES-1:0] next_mask,
    output logic             next_zero
);

    assign taken_mask = cur_mask & pred;

    always_comb begin
        unique case (op)
            OP_PUSH: next_mask = taken_mask;
            OP_FLIP: next_mask = top_saved & ~top_taken;
            OP_POP:  next_mask = top_saved;
            default: next_mask = cur_mask;
        endcase
    end

    assign next_zero = ~|next_mask;

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [LANES-1:0] lane_pred,
    output logic [LANES-1:0] active_mask,
    output logic             skip_path,
    output logic             stack_fault
);

    localparam int CW = $clog2(DEPTH + 1);

    div_op_e          op;
    div_state_e       state_q;
    div_state_e       state_d;
    logic [LANES-1:0] top_saved;
    logic [LANES-1:0] top_taken;
    logic [LANES-1:0] taken_mask;
    logic [LANES-1:0] next_mask;
    logic             next_zero;
    logic [CW-1:0]    stk_depth;
    logic             stk_empty;
    logic             stk_full;
    logic             stk_last;
    logic             op_bad;
    logic             op_go;
    logic             do_push;
    logic             do_pop;

    assign op      = div_op_e'(op_code);
    assign op_bad  = ((op == OP_PUSH) && stk_full) ||
                     (((op == OP_FLIP) || (op == OP_POP)) && stk_empty);
    assign op_go   = op_valid && (state_q != ST_FAULT) && !op_bad;
    assign do_push = op_go && (op == OP_PUSH);
    assign do_pop  = op_go && (op == OP_POP);

    simt_mask_lifo #(
        .LANES (LANES),
        .DEPTH (DEPTH),
        .CW    (CW)
    ) u_lifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .pop      (do_pop),
        .wr_saved (active_mask),
        .wr_taken (taken_mask),
        .rd_saved (top_saved),
        .rd_taken (top_taken),
        .depth    (stk_depth),
        .empty    (stk_empty),
        .full     (stk_full),
        .last     (stk_last)
    );

    simt_mask_calc #(
        .LANES (LANES)
    ) u_calc (
        .op         (op),
        .cur_mask   (active_mask),
        .pred       (lane_pred),
        .top_saved  (top_saved),
        .top_taken  (top_taken),
        .taken_mask (taken_mask),
        .next_mask  (next_mask),
        .next_zero  (next_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CONVERGED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONVERGED: begin
                if (op_valid && op_bad) begin
                    state_d = ST_FAULT;
                end else if (do_push) begin
                    state_d = ST_DIVERGED;
                end
            end
            ST_DIVERGED: begin
                if (op_valid && op_bad) begin
                    state_d = ST_FAULT;
                end else if (do_pop && stk_last) begin
                    state_d = ST_CONVERGED;
                end
            end
            ST_FAULT: begin
                state_d = ST_FAULT;
            end
            default: begin
                state_d = ST_FAULT;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_mask <= '1;
            skip_path   <= 1'b0;
        end else if (op_go) begin
            unique case (op)
                OP_PUSH, OP_FLIP: begin
                    active_mask <= next_mask;
                    skip_path   <= next_zero;
                end
                OP_POP: begin
                    active_mask <= next_mask;
                    skip_path   <= 1'b0;
                end
                default: begin
                    active_mask <= active_mask;
                    skip_path   <= skip_path;
                end
            endcase
        end
    end

    assign stack_fault = (state_q == ST_FAULT);

endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [1:0]       op_code,
    input logic [LANES-1:0] active_mask,
    input logic             skip_path,
    input logic             stack_fault,
    input logic [CW-1:0]    depth
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    AST_PUSH_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && op_valid && (op_code == 2'b01) |=> ((active_mask & ~$past(active_mask)) == '0)); // R2

    AST_SKIP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        skip_path |-> (active_mask == '0)); // R5

    AST_POP_CLEARS_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && op_valid && (op_code == 2'b11) && !stack_fault |=> !skip_path); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !op_valid |=> $stable(active_mask) && $stable(skip_path) && $stable(stack_fault)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CW'(DEPTH)); // R7

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_fault |=> stack_fault && $stable(active_mask) && $stable(skip_path)); // R9

endmodule

bind simt_mask_stack simt_mask_stack_chk #(
    .LANES (LANES),
    .DEPTH (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .active_mask (active_mask),
    .skip_path   (skip_path),
    .stack_fault (stack_fault),
    .depth       (stk_depth)
);

// File: tb/simt_mask_stack_tb.sv
`timescale 1ns/100ps
module simt_mask_stack_tb;

    localparam int LANES = 32;
    localparam int DEPTH = 8;
    localparam int NVEC  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic [1:0]       op_code = 2'b00;
    logic [LANES-1:0] lane_pred = '0;
    logic [LANES-1:0] active_mask;
    logic             skip_path;
    logic             stack_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_code     (op_code),
        .lane_pred   (lane_pred),
        .active_mask (active_mask),
        .skip_path   (skip_path),
        .stack_fault (stack_fault)
    );

    // {valid, op, pred, expected mask, expected skip}
    localparam logic [67:0] VEC [NVEC] = '{
        {1'b1, 2'b01, 32'h0000_FFFF, 32'h0000_FFFF, 1'b0}, // R2 outer entry
        {1'b1, 2'b01, 32'h0000_00FF, 32'h0000_00FF, 1'b0}, // R2 nested entry
        {1'b1, 2'b10, 32'h0000_0000, 32'h0000_FF00, 1'b0}, // R3 nested else
        {1'b1, 2'b11, 32'h0000_0000, 32'h0000_FFFF, 1'b0}, // R4 nested rejoin
        {1'b1, 2'b10, 32'h0000_0000, 32'hFFFF_0000, 1'b0}, // R3 outer else
        {1'b1, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_0000, 1'b0}, // R6 none code
        {1'b0, 2'b01, 32'h0000_0000, 32'hFFFF_0000, 1'b0}, // R6 not valid
        {1'b1, 2'b01, 32'h00FF_00FF, 32'h00FF_0000, 1'b0}, // R2 inactive pred ignored
        {1'b1, 2'b01, 32'h0000_FFFF, 32'h0000_0000, 1'b1}, // R5 skip on empty entry
        {1'b1, 2'b10, 32'h0000_0000, 32'h00FF_0000, 1'b0}, // R3 else after skip
        {1'b1, 2'b11, 32'h0000_0000, 32'h00FF_0000, 1'b0}, // R4
        {1'b1, 2'b11, 32'h0000_0000, 32'hFFFF_0000, 1'b0}, // R4
        {1'b1, 2'b11, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0}, // R4 fully rejoined
        {1'b1, 2'b01, 32'h0000_0000, 32'h0000_0000, 1'b1}, // R5 top-level skip
        {1'b1, 2'b10, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0}, // R3
        {1'b1, 2'b11, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0}  // R5 pop clears skip
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge; results are read at the next falling edge
    task automatic apply(input logic v, input logic [1:0] op, input logic [LANES-1:0] pred);
        op_valid  = v;
        op_code   = op;
        lane_pred = pred;
        @(negedge clk);
        op_valid  = 1'b0;
        op_code   = 2'b00;
        lane_pred = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        check("R1 mask", 64'(active_mask), 64'(32'hFFFF_FFFF));
        check("R1 skip", 64'(skip_path), 64'd0);
        check("R1 fault", 64'(stack_fault), 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][67], VEC[i][66:65], VEC[i][64:33]);
            check($sformatf("R2-R6 vec %0d mask", i), 64'(active_mask), 64'(VEC[i][32:1]));
            check($sformatf("R5 vec %0d skip", i), 64'(skip_path), 64'(VEC[i][0]));
            check($sformatf("R8 vec %0d fault", i), 64'(stack_fault), 64'd0);
        end

        // R8: pop on empty LIFO
        apply(1'b1, 2'b11, '0);
        check("R8 pop underflow fault", 64'(stack_fault), 64'd1);
        check("R8 pop underflow mask", 64'(active_mask), 64'(32'hFFFF_FFFF));
        // R9: frozen after fault
        apply(1'b1, 2'b01, 32'h0000_0001);
        check("R9 fault held", 64'(stack_fault), 64'd1);
        check("R9 push ignored", 64'(active_mask), 64'(32'hFFFF_FFFF));
        apply(1'b1, 2'b01, 32'h0000_0000);
        check("R9 skip unchanged", 64'(skip_path), 64'd0);

        do_reset();
        check("R1 reset clears fault", 64'(stack_fault), 64'd0);
        // R8: else-switch on empty LIFO
        apply(1'b1, 2'b10, '0);
        check("R8 flip underflow fault", 64'(stack_fault), 64'd1);
        check("R8 flip underflow mask", 64'(active_mask), 64'(32'hFFFF_FFFF));

        do_reset();
        // R7: exactly DEPTH entries accepted
        for (int k = 0; k < DEPTH; k++) begin
            apply(1'b1, 2'b01, 32'hFFFF_FFFF >> k);
        end
        check("R7 full depth no fault", 64'(stack_fault), 64'd0);
        check("R7 full depth mask", 64'(active_mask), 64'(32'hFFFF_FFFF >> (DEPTH - 1)));
        apply(1'b1, 2'b01, 32'h0000_0000);
        check("R7 overflow fault", 64'(stack_fault), 64'd1);
        check("R7 overflow mask kept", 64'(active_mask), 64'(32'hFFFF_FFFF >> (DEPTH - 1)));
        check("R7 overflow no skip", 64'(skip_path), 64'd0);
        apply(1'b1, 2'b11, '0);
        check("R9 pop ignored in fault", 64'(active_mask), 64'(32'hFFFF_FFFF >> (DEPTH - 1)));

        finish_run();
    end

endmodule